// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block lets a host that only has a small I/O bus reach device configuration space. It uses an indirect two-port scheme. The host first writes a control word to the address port. The control word carries an enable bit, a function number and a doubleword register number. A later access to the data port turns into a single configuration request. That request carries a command code, a formatted configuration address, the host byte enables and, for writes, the host data.

Read data from a configuration read comes back to the host through a one-cycle valid pulse. While a request is outstanding the bridge raises a busy flag and drops every host strobe. Only one request can be in flight at a time. Accesses to any other I/O address leave the bridge untouched.

Top module: `cfg_port_bridge`

## Requirements
- R1: After a synchronous active-low reset, io_busy, cfg_req and io_rvalid are 0, and the stored control word is 0, so a read of the address port returns 0x00000000.
- R2: A write to I/O address 0x0CF8 updates each byte lane of the stored control word whose io_be bit is set and keeps the other lanes. Bits 1:0 are always stored as 0. A read of 0x0CF8 returns the stored word in io_rdata together with a one-cycle io_rvalid pulse in the cycle after the strobe.
- R3: An access to the data port 0x0CFC while bit 31 of the stored word is 0 (including the case of no address write since reset) issues no request. A read of this kind returns 0xFFFFFFFF with io_rvalid in the next cycle.
- R4: A data-port read while bit 31 is 1 raises cfg_req in the cycle after the strobe, with cfg_cmd = 4'b1010.
- R5: A data-port write while bit 31 is 1 raises cfg_req in the cycle after the strobe, with cfg_cmd = 4'b1011 and cfg_wdata equal to the host write data.
- R6: cfg_addr has bits 1:0 = 0, bits 7:2 = stored bits 7:2 (register number), bits 10:8 = stored bits 10:8 (function number) and bits 31:11 = 0.
- R7: cfg_be equals the io_be value of the data-port access that started the request.
- R8: While a request is outstanding, io_busy is 1 and cfg_req, cfg_cmd, cfg_addr, cfg_be and cfg_wdata hold steady. Host strobes in that time are ignored, including writes to the address port.
- R9: cfg_done sampled with cfg_req high drops cfg_req and io_busy in the next cycle. For a read, the same cycle shows io_rdata = cfg_rdata with io_rvalid = 1. cfg_done with no request outstanding has no effect.
- R10: Strobes to any address other than 0x0CF8 and 0x0CFC are ignored, and so is a cycle with io_rd and io_wr both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 32 | Host write data |
| io_be | input | 4 | Host byte enables, one per lane |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rdata | output | 32 | Read data returned to host |
| io_rvalid | output | 1 | io_rdata valid pulse |
| io_busy | output | 1 | Request outstanding; strobes dropped |
| cfg_req | output | 1 | Configuration request, held until done |
| cfg_cmd | output | 4 | 1010 read, 1011 write |
| cfg_addr | output | 32 | Formatted configuration address |
| cfg_be | output | 4 | Lane-valid mask |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_done | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Downstream read data |

## Verification
The hardest case to reach is a host strobe that arrives while a request is still outstanding. Such a strobe must neither disturb the held request nor change the stored control word. The bench keeps cfg_done low on purpose and issues an address-port write and a data-port read during that window. After completion it reads the address port back, which shows that the stored word is unchanged. A sweep over all register and function numbers covers every field value, with byte enables that vary between accesses and read and write requests taking turns.

// File: rtl/cfg_bridge_pkg.sv
// Shared constants and types for the configuration port bridge.
// Assumes a 32-bit host data path split into byte lanes.
package cfg_bridge_pkg;
    localparam int CFG_DW    = 32;
    localparam int CFG_LANES = CFG_DW / 8;
    localparam int REG_LSB   = 2;
    localparam int REG_W     = 6;
    localparam int FN_LSB    = 8;
    localparam int FN_W      = 3;
    localparam int EN_BIT    = CFG_DW - 1;

    typedef enum logic [3:0] {
        CMD_CFG_RD = 4'b1010,
        CMD_CFG_WR = 4'b1011
    } cfg_cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } req_state_e;
endpackage

// File: rtl/cfg_addr_latch.sv
// Stored control word written through the address port.
// Each byte lane updates only when its enable is set; bits 1:0 are kept zero.
// Assumes wr_en is already gated by port decode and the busy flag.
module cfg_addr_latch
    import cfg_bridge_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CFG_DW-1:0]    wdata,
    input  logic [CFG_LANES-1:0] be,
    output logic [CFG_DW-1:0]    q
);
    generate
        for (genvar g = 0; g < CFG_LANES; g++) begin : g_lane
            if (g == 0) begin : g_low
                // Lowest lane: keep the doubleword alignment bits at zero.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q[7:0] <= '0;
                    else if (wr_en && be[0])
                        q[7:0] <= {wdata[7:2], 2'b00};
                end
            end else begin : g_up
                // Upper lanes: plain byte merge under the lane enable.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q[8*g +: 8] <= '0;
                    else if (wr_en && be[g])
                        q[8*g +: 8] <= wdata[8*g +: 8];
                end
            end
        end
    endgenerate

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q))
        else $error("control word changed without a write");
endmodule

// File: rtl/cfg_addr_format.sv
// Builds the configuration address from the stored register and function
// fields. The alignment bits and every bit above the function field are zero.
module cfg_addr_format
    import cfg_bridge_pkg::*;
(
    input  logic [REG_W-1:0]  reg_num,
    input  logic [FN_W-1:0]   fn_num,
    output logic [CFG_DW-1:0] cfg_addr
);
    // Place each field at its fixed position; all other bits stay zero.
    always_comb begin
        cfg_addr                    = '0;
        cfg_addr[REG_LSB +: REG_W]  = reg_num;
        cfg_addr[FN_LSB  +: FN_W]   = fn_num;
    end
endmodule

// File: rtl/cfg_req_ctrl.sv
// Request sequencer: starts one configuration request per enabled data-port
// access, holds it until completion and returns read data to the host.
// Assumes the access inputs are single-cycle and already decoded.
module cfg_req_ctrl
    import cfg_bridge_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dp_rd,
    input  logic                 dp_wr,
    input  logic                 ap_rd,
    input  logic                 enable,
    input  logic [CFG_DW-1:0]    fmt_addr,
    input  logic [CFG_DW-1:0]    ctl_word,
    input  logic [CFG_LANES-1:0] host_be,
    input  logic [CFG_DW-1:0]    host_wdata,
    input  logic                 cfg_done,
    input  logic [CFG_DW-1:0]    cfg_rdata,
    output logic                 cfg_req,
    output cfg_cmd_e             cfg_cmd,
    output logic [CFG_DW-1:0]    cfg_addr,
    output logic [CFG_LANES-1:0] cfg_be,
    output logic [CFG_DW-1:0]    cfg_wdata,
    output logic [CFG_DW-1:0]    io_rdata,
    output logic                 io_rvalid,
    output logic                 busy
);
    req_state_e state;

    // Sequencer state, request fields and host read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cfg_req   <= 1'b0;
            cfg_cmd   <= CMD_CFG_RD;
            cfg_addr  <= '0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
            io_rdata  <= '0;
            io_rvalid <= 1'b0;
        end else begin
            io_rvalid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if ((dp_rd || dp_wr) && enable) begin
                        state     <= ST_WAIT;
                        cfg_req   <= 1'b1;
                        cfg_cmd   <= dp_wr ? CMD_CFG_WR : CMD_CFG_RD;
                        cfg_addr  <= fmt_addr;
                        cfg_be    <= host_be;
                        cfg_wdata <= dp_wr ? host_wdata : '0;
                    end else if (dp_rd) begin
                        io_rvalid <= 1'b1;
                        io_rdata  <= '1;
                    end else if (ap_rd) begin
                        io_rvalid <= 1'b1;
                        io_rdata  <= ctl_word;
                    end
                end
                ST_WAIT: begin
                    if (cfg_done) begin
                        state   <= ST_IDLE;
                        cfg_req <= 1'b0;
                        if (cfg_cmd == CMD_CFG_RD) begin
                            io_rvalid <= 1'b1;
                            io_rdata  <= cfg_rdata;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Busy mirrors the waiting state.
    always_comb busy = (state == ST_WAIT);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_done |=> cfg_req && $stable(cfg_addr) && $stable(cfg_cmd)
                                 && $stable(cfg_be) && $stable(cfg_wdata))
        else $error("request fields moved while outstanding");

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_done |=> !cfg_req && !busy)
        else $error("request not released after completion");

    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_rd || dp_wr) && !enable && !cfg_req |=> !cfg_req)
        else $error("request issued with enable clear");

    p_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> ((cfg_cmd == CMD_CFG_RD) == $past(dp_rd)))
        else $error("command does not match access direction");

    p_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_addr[1:0] == 2'b00) && (cfg_addr[CFG_DW-1:FN_LSB+FN_W] == '0))
        else $error("configuration address has stray bits");
endmodule

// File: rtl/cfg_port_bridge.sv
// Top of the configuration address/data port bridge. Decodes the host I/O
// strobes onto the address port and the data port, drops them while busy
// or when both strobes are high, and wires the control word, the address
// formatter and the request sequencer together.
module cfg_port_bridge
    import cfg_bridge_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic [CFG_DW-1:0]    io_wdata,
    input  logic [CFG_LANES-1:0] io_be,
    input  logic                 io_rd,
    input  logic                 io_wr,
    output logic [CFG_DW-1:0]    io_rdata,
    output logic                 io_rvalid,
    output logic                 io_busy,
    output logic                 cfg_req,
    output logic [3:0]           cfg_cmd,
    output logic [CFG_DW-1:0]    cfg_addr,
    output logic [CFG_LANES-1:0] cfg_be,
    output logic [CFG_DW-1:0]    cfg_wdata,
    input  logic                 cfg_done,
    input  logic [CFG_DW-1:0]    cfg_rdata
);
    logic              hit_ap, hit_dp, acc_ok;
    logic              ap_wr, ap_rd, dp_rd, dp_wr;
    logic [CFG_DW-1:0] ctl_word, fmt_addr;
    cfg_cmd_e          cmd_q;

    // Port decode: one strobe only, bridge idle, exact address match.
    always_comb begin
        hit_ap = (io_addr == ADDR_PORT[IO_AW-1:0]);
        hit_dp = (io_addr == DATA_PORT[IO_AW-1:0]);
        acc_ok = (io_rd ^ io_wr) && !io_busy;
        ap_wr  = acc_ok && io_wr && hit_ap;
        ap_rd  = acc_ok && io_rd && hit_ap;
        dp_wr  = acc_ok && io_wr && hit_dp;
        dp_rd  = acc_ok && io_rd && hit_dp;
    end

    cfg_addr_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ap_wr),
        .wdata (io_wdata),
        .be    (io_be),
        .q     (ctl_word)
    );

    cfg_addr_format u_fmt (
        .reg_num  (ctl_word[REG_LSB +: REG_W]),
        .fn_num   (ctl_word[FN_LSB +: FN_W]),
        .cfg_addr (fmt_addr)
    );

    cfg_req_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dp_rd      (dp_rd),
        .dp_wr      (dp_wr),
        .ap_rd      (ap_rd),
        .enable     (ctl_word[EN_BIT]),
        .fmt_addr   (fmt_addr),
        .ctl_word   (ctl_word),
        .host_be    (io_be),
        .host_wdata (io_wdata),
        .cfg_done   (cfg_done),
        .cfg_rdata  (cfg_rdata),
        .cfg_req    (cfg_req),
        .cfg_cmd    (cmd_q),
        .cfg_addr   (cfg_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .io_rdata   (io_rdata),
        .io_rvalid  (io_rvalid),
        .busy       (io_busy)
    );

    // Present the command as a plain code on the port.
    always_comb cfg_cmd = cmd_q;

    p_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_busy && (io_rd || io_wr) && !hit_ap && !hit_dp |=> !io_rvalid && !cfg_req)
        else $error("bridge reacted to a foreign address");
endmodule

// File: tb/cfg_port_bridge_tb.sv
// Self-checking bench: sweeps the control-word fields, byte enables and
// access directions, and models the downstream side by hand.
module cfg_port_bridge_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic [3:0]  io_be = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [31:0] io_rdata;
    logic        io_rvalid, io_busy, cfg_req;
    logic [3:0]  cfg_cmd;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [3:0]  cfg_be;
    logic        cfg_done = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_be(io_be), .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
        .io_rvalid(io_rvalid), .io_busy(io_busy), .cfg_req(cfg_req),
        .cfg_cmd(cfg_cmd), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_done(cfg_done), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One-cycle strobe; returns at the falling edge after the sampling edge.
    task automatic host(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d; io_be = be;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++)
            if (be[i]) r[8*i +: 8] = d[8*i +: 8];
        r[1:0] = 2'b00;
        return r;
    endfunction

    task automatic ap_write(input logic [31:0] d, input logic [3:0] be);
        host(16'h0CF8, 1'b0, 1'b1, d, be);
        model = merge(model, d, be);
    endtask

    task automatic ap_check(input string tag);
        host(16'h0CF8, 1'b1, 1'b0, 32'h0, 4'hF);
        chk({tag, " rvalid"}, {31'b0, io_rvalid}, 32'd1);
        chk({tag, " rdata"}, io_rdata, model);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 busy", {31'b0, io_busy}, 32'd0);
        chk("R1 req", {31'b0, cfg_req}, 32'd0);
        chk("R1 rvalid", {31'b0, io_rvalid}, 32'd0);
        rst_n = 1'b1;
        ap_check("R1 control word after reset");

        // R3: data port with enable never set
        host(16'h0CFC, 1'b1, 1'b0, 32'h0, 4'hF);
        chk("R3 rvalid", {31'b0, io_rvalid}, 32'd1);
        chk("R3 ones", io_rdata, 32'hFFFF_FFFF);
        chk("R3 no req rd", {31'b0, cfg_req}, 32'd0);
        host(16'h0CFC, 1'b0, 1'b1, 32'h1234_5678, 4'hF);
        chk("R3 no req wr", {31'b0, cfg_req}, 32'd0);
        chk("R3 wr busy", {31'b0, io_busy}, 32'd0);

        // R2: byte-lane merge over every enable pattern
        for (int b = 0; b < 16; b++) begin
            ap_write(32'h1357_9BDF + 32'h1111_1111 * b, b[3:0]);
            ap_check("R2 lane merge");
        end

        // R3: fields set but enable clear
        ap_write(32'h0000_0F3C, 4'hF);
        host(16'h0CFC, 1'b1, 1'b0, 32'h0, 4'hF);
        chk("R3 ones with fields", io_rdata, 32'hFFFF_FFFF);
        chk("R3 no req with fields", {31'b0, cfg_req}, 32'd0);

        // R10: foreign addresses and double strobes
        host(16'h0CF9, 1'b0, 1'b1, 32'hDEAD_BEEF, 4'hF);
        host(16'h0CFD, 1'b0, 1'b1, 32'hDEAD_BEEF, 4'hF);
        host(16'h0CF4, 1'b1, 1'b0, 32'h0, 4'hF);
        chk("R10 foreign read rvalid", {31'b0, io_rvalid}, 32'd0);
        host(16'h0CF8, 1'b1, 1'b1, 32'hFFFF_FFFF, 4'hF);
        chk("R10 double strobe rvalid", {31'b0, io_rvalid}, 32'd0);
        ap_check("R10 control word untouched");

        // R9: stray completion while idle
        @(negedge clk); cfg_done = 1'b1; cfg_rdata = 32'hA5A5_A5A5;
        @(negedge clk); cfg_done = 1'b0;
        chk("R9 idle done rvalid", {31'b0, io_rvalid}, 32'd0);
        chk("R9 idle done req", {31'b0, cfg_req}, 32'd0);

        // R4 R5 R6 R7 R8 R9: sweep register and function numbers
        for (int rn = 0; rn < 64; rn++) begin
            for (int fn = 0; fn < 8; fn++) begin
                logic [31:0] word, exp_addr, wd, rd_val;
                logic [3:0]  be;
                logic        is_wr;
                word     = 32'h80AB_F803 | (32'(fn) << 8) | (32'(rn) << 2);
                exp_addr = (32'(fn) << 8) | (32'(rn) << 2);
                be       = 4'((rn ^ fn) & 15);
                is_wr    = ((rn + fn) % 2) == 1;
                wd       = 32'hC000_0000 | (32'(rn) << 8) | 32'(fn);
                rd_val   = 32'h5000_0000 | (32'(fn) << 12) | 32'(rn);
                ap_write(word, 4'hF);
                host(16'h0CFC, ~is_wr, is_wr, wd, be);
                chk("R8 busy", {31'b0, io_busy}, 32'd1);
                chk(is_wr ? "R5 cmd" : "R4 cmd", {28'b0, cfg_cmd},
                    is_wr ? 32'hB : 32'hA);
                chk("R6 addr", cfg_addr, exp_addr);
                chk("R7 be", {28'b0, cfg_be}, {28'b0, be});
                if (is_wr) chk("R5 wdata", cfg_wdata, wd);
                if (fn == 0) begin
                    // R8: strobes while outstanding are dropped
                    host(16'h0CF8, 1'b0, 1'b1, 32'h7FFF_FFFF, 4'hF);
                    host(16'h0CFC, 1'b1, 1'b0, 32'h0, 4'hF);
                    chk("R8 no rvalid", {31'b0, io_rvalid}, 32'd0);
                    chk("R8 req held", {31'b0, cfg_req}, 32'd1);
                    chk("R8 addr held", cfg_addr, exp_addr);
                end
                repeat (rn % 3) @(negedge clk);
                chk("R8 req before done", {31'b0, cfg_req}, 32'd1);
                @(negedge clk); cfg_done = 1'b1; cfg_rdata = rd_val;
                @(negedge clk); cfg_done = 1'b0;
                chk("R9 req drop", {31'b0, cfg_req}, 32'd0);
                chk("R9 busy drop", {31'b0, io_busy}, 32'd0);
                chk("R9 rvalid", {31'b0, io_rvalid}, {31'b0, ~is_wr});
                if (!is_wr) chk("R9 rdata", io_rdata, rd_val);
                if (fn == 0) ap_check("R8 control word kept");
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule